// File: doc/BRIEF.md
# Digital Constant Fraction Discriminator

This block turns one captured window of digitized waveform samples into an arrival time with sub-sample resolution. Each sample is converted to a signed amplitude above a programmable baseline and, for negative-going pulses, inverted. The amplitude is written into an internal buffer while the largest value in the window is tracked. Once the window closes, a threshold is formed as a programmable fraction of that peak. Because the threshold scales with each pulse's own height, the measured time does not drift with amplitude.

After the window closes, the block rereads the buffer from the sample just before the peak and moves toward earlier samples. It stops at the first sample at or below the threshold. That sample and its later neighbour bracket the crossing. A multi-cycle restoring divider then interpolates linearly between them. The result is an integer sample index plus an 8-bit fraction, flagged by a one-cycle valid pulse. An error flag marks windows that hold no usable crossing. Samples are accepted only while the block reports that it is ready for a new window.

Top module: `cfd_timer`

## Requirements
- R1: Each accepted sample gives the amplitude a[k] = smp_data - baseline, both read as two's-complement; when neg_pol is 1 the amplitude is negated. Sample k is the k-th accepted sample of the window, counted from 0.
- R2: The peak is the largest a[k] in the window. If several samples share that value, the earliest one is the peak, and the backward search starts from it.
- R3: The threshold is th = floor(peak * frac_q / 256), where frac_q is an unsigned 0.8 fraction (for example, 59 gives about 0.23).
- R4: res_index is the largest i below the peak index with a[i] <= th. Every sample between i and the peak lies above th.
- R5: res_frac = floor(256 * (th - a[i]) / (a[i+1] - a[i])), so the time of the crossing is res_index + res_frac/256.
- R6: A window closes on the sample that carries smp_last, or on the WIN_LEN-th accepted sample, whichever comes first.
- R7: If the peak is at index 0, or no sample before the peak is at or below th, the result has res_err = 1 with res_index = 0 and res_frac = 0.
- R8: If the peak amplitude is zero or negative, the result has res_err = 1 with res_index = 0 and res_frac = 0.
- R9: in_ready is low from the close of a window until the result has been issued. Samples offered while in_ready is low are ignored and affect neither the current result nor the next window.
- R10: res_valid is a single-cycle pulse, one per window. After reset, in_ready is 1 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample is present on smp_data |
| smp_data | input | SMP_W | Signed raw sample |
| smp_last | input | 1 | Marks the final sample of a window |
| baseline | input | SMP_W | Signed level subtracted from every sample |
| frac_q | input | FRAC_W | Unsigned threshold fraction, frac_q/2^FRAC_W |
| neg_pol | input | 1 | 1 selects negative-going pulses |
| in_ready | output | 1 | High while samples of a window are accepted |
| res_valid | output | 1 | One-cycle result strobe |
| res_index | output | IDX_W | Integer sample index of the crossing |
| res_frac | output | FRAC_W | Fractional part of the crossing time |
| res_err | output | 1 | No usable crossing in this window |

## Verification
A wrong peak register or peak index shows up at the ports in the very next result. It appears as a shifted res_index, or as an error flag raised or dropped on a window built to sit on the other side of that case. A corrupted threshold or bracketing sample shows up only in res_frac, and only on the same result strobe. The bench therefore uses pulses of different heights, plateaus and exact-threshold samples, so that each internal register changes a visible field. A stuck ready or a missed window close shows up at once, as the next window's result being absent or wrong.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
   typedef enum logic [2:0] {
      ST_CAP,
      ST_THR,
      ST_WAIT,
      ST_CHK,
      ST_DIV,
      ST_OUT
   } cfd_state_e;
endpackage

// File: rtl/cfd_amp_conv.sv
module cfd_amp_conv #(
   parameter int SMP_W = 12,
   parameter int AMP_W = SMP_W + 2
) (
   input  logic signed [SMP_W-1:0] raw,
   input  logic signed [SMP_W-1:0] base,
   input  logic                    neg,
   output logic signed [AMP_W-1:0] amp
);
   localparam int EXT = AMP_W - SMP_W;

   generate
      if (EXT < 2) begin : g_bad_width
         $error("cfd_amp_conv: AMP_W must exceed SMP_W by at least 2");
      end
   endgenerate

   logic signed [AMP_W-1:0] diff;

   always_comb begin
      diff = $signed({{EXT{raw[SMP_W-1]}}, raw}) - $signed({{EXT{base[SMP_W-1]}}, base});
      amp  = neg ? -diff : diff;
   end
endmodule

// File: rtl/cfd_sample_buf.sv
module cfd_sample_buf #(
   parameter int DEPTH = 1024,
   parameter int DW    = 14,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/cfd_frac_div.sv
module cfd_frac_div #(
   parameter int DW = 15,
   parameter int QW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [QW-1:0] quo
);
   localparam int CW = $clog2(QW + 1);

   logic [DW-1:0] rem, dsr;
   logic [CW-1:0] cnt;
   logic          busy;
   logic [DW:0]   sh, diff;
   logic          ge;

   always_comb begin
      sh   = {rem, 1'b0};
      diff = sh - {1'b0, dsr};
      ge   = !diff[DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         dsr  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
         quo  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem  <= num;
            dsr  <= den;
            cnt  <= CW'(QW);
            busy <= 1'b1;
         end else if (busy) begin
            rem <= ge ? diff[DW-1:0] : sh[DW-1:0];
            quo <= {quo[QW-2:0], ge};
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R5: the partial remainder stays below the divisor during every step
   a_r5_rem_below_dsr: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem < dsr));
   // R5: a result strobe always ends a running division
   a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
   import cfd_pkg::*;
#(
   parameter int SMP_W   = 12,
   parameter int WIN_LEN = 1024,
   parameter int FRAC_W  = 8,
   parameter int IDX_W   = $clog2(WIN_LEN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic signed [SMP_W-1:0] smp_data,
   input  logic                    smp_last,
   input  logic signed [SMP_W-1:0] baseline,
   input  logic [FRAC_W-1:0]       frac_q,
   input  logic                    neg_pol,
   output logic                    in_ready,
   output logic                    res_valid,
   output logic [IDX_W-1:0]        res_index,
   output logic [FRAC_W-1:0]       res_frac,
   output logic                    res_err
);
   localparam int AMP_W  = SMP_W + 2;
   localparam int PROD_W = AMP_W + FRAC_W + 1;
   localparam int DIV_W  = AMP_W + 1;

   generate
      if (WIN_LEN < 2 || WIN_LEN > 1024) begin : g_bad_len
         $error("cfd_timer: WIN_LEN must lie in 2..1024");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("cfd_timer: FRAC_W must be at least 2");
      end
      if (IDX_W < $clog2(WIN_LEN)) begin : g_bad_idx
         $error("cfd_timer: IDX_W too narrow for WIN_LEN");
      end
   endgenerate

   cfd_state_e              st;
   logic [IDX_W-1:0]        cnt, pk_idx, j;
   logic signed [AMP_W-1:0] amp, pk, th, upper, lo, rd_q;
   logic signed [PROD_W-1:0] prod, th_wide;
   logic signed [DIV_W-1:0] num_s, den_s;
   logic                    wr_en, last_in, div_start, div_done;
   logic [FRAC_W-1:0]       quo;

   cfd_amp_conv #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_conv (
      .raw (smp_data),
      .base(baseline),
      .neg (neg_pol),
      .amp (amp)
   );

   cfd_sample_buf #(.DEPTH(WIN_LEN), .DW(AMP_W), .AW(IDX_W)) u_buf (
      .clk  (clk),
      .we   (wr_en),
      .waddr(cnt),
      .wdata(amp),
      .raddr(j),
      .rdata(rd_q)
   );

   cfd_frac_div #(.DW(DIV_W), .QW(FRAC_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(div_start),
      .num  ($unsigned(num_s)),
      .den  ($unsigned(den_s)),
      .done (div_done),
      .quo  (quo)
   );

   always_comb begin
      in_ready = (st == ST_CAP);
      wr_en    = in_ready && smp_valid;
      last_in  = smp_last || (cnt == IDX_W'(WIN_LEN - 1));
      prod     = $signed({{(FRAC_W + 1){pk[AMP_W-1]}}, pk}) *
                 $signed({{(AMP_W + 1){1'b0}}, frac_q});
      th_wide  = prod >>> FRAC_W;
      num_s    = {th[AMP_W-1], th} - {lo[AMP_W-1], lo};
      den_s    = {upper[AMP_W-1], upper} - {lo[AMP_W-1], lo};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_CAP;
         cnt       <= '0;
         pk        <= '0;
         pk_idx    <= '0;
         th        <= '0;
         j         <= '0;
         upper     <= '0;
         lo        <= '0;
         div_start <= 1'b0;
         res_valid <= 1'b0;
         res_index <= '0;
         res_frac  <= '0;
         res_err   <= 1'b0;
      end else begin
         div_start <= 1'b0;
         res_valid <= 1'b0;
         case (st)
            ST_CAP: if (smp_valid) begin
               if (cnt == '0 || amp > pk) begin
                  pk     <= amp;
                  pk_idx <= cnt;
               end
               if (last_in) begin
                  cnt <= '0;
                  st  <= ST_THR;
               end else begin
                  cnt <= cnt + IDX_W'(1);
               end
            end
            ST_THR: begin
               th    <= th_wide[AMP_W-1:0];
               upper <= pk;
               if (pk[AMP_W-1] || pk == '0 || pk_idx == '0) begin
                  res_valid <= 1'b1;
                  res_err   <= 1'b1;
                  res_index <= '0;
                  res_frac  <= '0;
                  st        <= ST_OUT;
               end else begin
                  j  <= pk_idx - IDX_W'(1);
                  st <= ST_WAIT;
               end
            end
            ST_WAIT: st <= ST_CHK;
            ST_CHK: begin
               if (rd_q <= th) begin
                  lo        <= rd_q;
                  div_start <= 1'b1;
                  st        <= ST_DIV;
               end else if (j == '0) begin
                  res_valid <= 1'b1;
                  res_err   <= 1'b1;
                  res_index <= '0;
                  res_frac  <= '0;
                  st        <= ST_OUT;
               end else begin
                  upper <= rd_q;
                  j     <= j - IDX_W'(1);
                  st    <= ST_WAIT;
               end
            end
            ST_DIV: if (div_done) begin
               res_valid <= 1'b1;
               res_err   <= 1'b0;
               res_index <= j;
               res_frac  <= quo;
               st        <= ST_OUT;
            end
            ST_OUT: st <= ST_CAP;
            default: st <= ST_CAP;
         endcase
      end
   end

   // R3: the scaled threshold always fits the amplitude width
   a_r3_th_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_THR) |-> (th_wide[PROD_W-1:AMP_W-1] == '0 || th_wide[PROD_W-1:AMP_W-1] == '1));
   // R4: the later sample of the bracketing pair stays above the threshold
   a_r4_upper_above_th: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CHK) |-> (upper > th));
   // R4: a good crossing lies strictly before the peak
   a_r4_index_before_peak: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_err) |-> (res_index < pk_idx));
   // R5: interpolation numerator is non-negative and below the denominator
   a_r5_num_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |-> (num_s >= 0 && num_s < den_s));
   // R7: an error result carries zeroed index and fraction
   a_r7_err_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_err) |-> (res_index == '0 && res_frac == '0));
   // R9: no samples are taken while a result is issued
   a_r9_busy_at_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !in_ready);
   // R10: the result strobe lasts one cycle and the block reopens after it
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (!res_valid && in_ready));
endmodule

// File: tb/cfd_timer_test.sv
module cfd_timer_test;
   localparam int SMP_W = 12;
   localparam int WIN   = 32;
   localparam int FW    = 8;
   localparam int IW    = $clog2(WIN);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    smp_valid = 1'b0;
   logic signed [SMP_W-1:0] smp_data = '0;
   logic                    smp_last = 1'b0;
   logic signed [SMP_W-1:0] baseline = '0;
   logic [FW-1:0]           frac_q = '0;
   logic                    neg_pol = 1'b0;
   logic                    in_ready, res_valid, res_err;
   logic [IW-1:0]           res_index;
   logic [FW-1:0]           res_frac;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      int    idx;
      int    fr;
      int    err;
      string tag;
   } exp_t;
   exp_t expq[$];

   always #5 clk = ~clk;

   cfd_timer #(.SMP_W(SMP_W), .WIN_LEN(WIN), .FRAC_W(FW)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_last(smp_last), .baseline(baseline), .frac_q(frac_q), .neg_pol(neg_pol),
      .in_ready(in_ready), .res_valid(res_valid), .res_index(res_index),
      .res_frac(res_frac), .res_err(res_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each result strobe
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (expq.size() == 0) begin
            chk("R10 unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk({e.tag, " err"}, int'(res_err), e.err);
            chk({e.tag, " index"}, int'(res_index), e.idx);
            chk({e.tag, " frac"}, int'(res_frac), e.fr);
         end
      end
   end

   // driver: computes the expected result, queues it, then plays the window
   task automatic run_window(input int raw[], input bit use_last, input int base,
                             input int fr, input bit neg, input int junk, input string tag);
      int   n, m, pk, pi, th;
      int   a[];
      exp_t e;
      n = raw.size();
      m = (n < WIN) ? n : WIN;
      a = new[m];
      for (int k = 0; k < m; k++) a[k] = neg ? -(raw[k] - base) : (raw[k] - base);
      pk = a[0];
      pi = 0;
      for (int k = 1; k < m; k++) if (a[k] > pk) begin pk = a[k]; pi = k; end
      e.tag = tag;
      e.err = 1;
      e.idx = 0;
      e.fr  = 0;
      if (pk > 0) begin
         th = (pk * fr) / 256;
         for (int k = pi - 1; k >= 0; k--) begin
            if (a[k] <= th) begin
               e.err = 0;
               e.idx = k;
               e.fr  = ((th - a[k]) * 256) / (a[k+1] - a[k]);
               break;
            end
         end
      end
      expq.push_back(e);
      while (!in_ready) @(negedge clk);
      baseline = SMP_W'(base);
      frac_q   = FW'(fr);
      neg_pol  = neg;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = SMP_W'(raw[k]);
         smp_last  = use_last && (k == n - 1);
      end
      for (int k = 0; k < junk; k++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = 12'sh7ff;
         smp_last  = 1'b1;
      end
      @(negedge clk);
      smp_valid = 1'b0;
      smp_last  = 1'b0;
      while (!in_ready) @(negedge clk);
   endtask

   function automatic void make_pulse(ref int w[], input int n, input int start,
                                      input int rise, input int amp, input int base);
      w = new[n];
      for (int k = 0; k < n; k++) begin
         int v;
         if (k < start) v = ((k * 7) % 5) - 2;
         else if (k < start + rise) v = (amp * (k - start + 1)) / rise;
         else v = amp - (amp * (k - start - rise + 1)) / (2 * rise);
         if (v < 0 && k >= start) v = 0;
         w[k] = base + v;
      end
   endfunction

   initial begin
      int w[];
      repeat (3) @(negedge clk);
      chk("R10 reset in_ready", int'(in_ready), 1);
      chk("R10 reset res_valid", int'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      make_pulse(w, 24, 5, 6, 1000, 100);
      run_window(w, 1, 100, 59, 0, 0, "R2 R3 R4 R5 basic");
      make_pulse(w, 24, 5, 6, 400, 100);
      run_window(w, 1, 100, 59, 0, 0, "R3 R5 small amp");
      make_pulse(w, 20, 3, 5, -800, -50);
      run_window(w, 1, -50, 59, 1, 0, "R1 negative");
      w = '{0, 0, 10, 50, 300, 300, 300, 100, 0};
      run_window(w, 1, 0, 128, 0, 0, "R2 plateau");
      w = '{0, 20, 100, 200, 40};
      run_window(w, 1, 0, 128, 0, 0, "R4 R5 exact th");
      w = '{500, 600, 900, 700};
      run_window(w, 1, 0, 59, 0, 0, "R7 no crossing");
      w = '{900, 300, 100};
      run_window(w, 1, 0, 59, 0, 0, "R7 peak first");
      w = '{-5, -10, 0, -3};
      run_window(w, 1, 0, 59, 0, 0, "R8 no pulse");
      make_pulse(w, WIN + 3, 10, 4, 1500, 0);
      run_window(w, 0, 0, 77, 0, 0, "R6 forced close");
      make_pulse(w, 16, 4, 3, 900, 20);
      run_window(w, 1, 20, 100, 0, 3, "R9 junk ignored");
      make_pulse(w, 12, 2, 4, 600, 20);
      run_window(w, 1, 20, 90, 0, 0, "R9 next window");
      make_pulse(w, 16, 4, 5, 700, 0);
      run_window(w, 1, 0, 0, 0, 0, "R3 zero fraction");
      w = '{2047, 2047, 1000, -2048, -1500, 2000};
      run_window(w, 1, 2047, 200, 1, 0, "R1 full scale");

      repeat (20) @(negedge clk);
      chk("R10 all results seen", expq.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule